// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block is the part of an 8-bit CPU core that takes the processor into and out of exception handlers. It watches the active-low maskable and non-maskable request pins, the decoded software-break and return-from-handler signals, and the core's instruction timing strobes. When the core finishes an instruction and a request is armed, the block takes over the byte-wide memory bus. It pushes the program counter and the status byte onto the stack page, fetches a two-byte handler address, and hands the core a new PC, status byte and stack pointer through load strobes.

The return sequence works the other way. It reads the status byte and then the two PC bytes back from the stack. After reset the block fetches the start address from the reset vector, with no stack traffic. While `busy` is high the core must hold off its own bus use and must not end an instruction. The accumulator and index registers are never touched by this block.

Top module: `cpu_int_entry`

## Requirements
- R1: After `rstN` rises, the block reads 0xFFFC (low byte) and then 0xFFFD (high byte). It loads the PC from them, loads status with bit 2 (I) set, and makes no stack writes.
- R2: Hardware or break entry writes three bytes. The PC high byte goes to 0x0100+SP, the PC low byte to 0x0100+SP-1 and the status byte to 0x0100+SP-2, in consecutive cycles. SP is then handed back as SP-3.
- R3: In the pushed status byte, bit 4 (B) is 0 for a hardware request and 1 for a break, and bit 5 is 1. All other bits are copied from `statusIn`.
- R4: The handler address is read little-endian: the low byte comes from the lower address. NMI uses 0xFFFA/0xFFFB, and IRQ and break share 0xFFFE/0xFFFF.
- R5: Every entry ends with a status load whose bit 2 (I) is set, in the same cycle as the PC load.
- R6: A low `irqN` is acted on only while `statusIn` bit 2 is 0.
- R7: A falling edge on `nmiN` is latched and serviced whatever the value of bit 2. A pin held low produces only one entry.
- R8: When NMI and IRQ are both pending at an instruction boundary, the NMI vector is used.
- R9: A request present in a cycle before the `penult` cycle is serviced when that instruction ends. A request first seen in the `penult` cycle or later waits until the following instruction ends.
- R10: Return reads status from 0x0100+SP+1, the PC low byte from SP+2 and the PC high byte from SP+3, and makes no writes. SP is handed back as SP+3.
- R11: The memory strobes are active only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; the reset fetch runs after release |
| irqN | input | 1 | Maskable request, level sensitive, active low |
| nmiN | input | 1 | Non-maskable request, falling-edge sensitive |
| instrEnd | input | 1 | Last cycle of the current instruction |
| penult | input | 1 | Second-to-last cycle of the current instruction |
| brkReq | input | 1 | Instruction ending this cycle is a software break |
| rtiReq | input | 1 | Instruction ending this cycle is a return from handler |
| pcIn | input | 16 | Core PC value to push |
| statusIn | input | 8 | Core status byte |
| spIn | input | 8 | Core stack pointer |
| memRdata | input | 8 | Read data, valid in the same cycle as the address |
| memAddr | output | 16 | Bus address |
| memWdata | output | 8 | Bus write data |
| memWe | output | 1 | Write strobe |
| memRe | output | 1 | Read strobe |
| pcOut | output | 16 | New PC value |
| pcLoad | output | 1 | Load pcOut into the core PC |
| statusOut | output | 8 | New status byte |
| statusLoad | output | 1 | Load statusOut into the core status |
| spOut | output | 8 | New stack pointer |
| spLoad | output | 1 | Load spOut into the core SP |
| busy | output | 1 | Sequence in progress |

## Verification
Several rules are checked by the assertions in every cycle. Bus strobes stay silent outside a sequence, writes only ever hit the stack page, and consecutive pushes step down by one address. Reads target only the stack page or the vector bytes, and any load from a vector comes with the I bit set. The bench scenarios are needed for the rest: the exact pushed bytes and the B bit, the choice of vector, masking by I, the one-shot nature of NMI and its priority over IRQ, the one-instruction delay for a request that arrives late, and the restore after a return.

// File: rtl/int_entry_pkg.sv
package int_entry_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam logic [7:0] STACK_PAGE = 8'h01;
  localparam logic [ADDR_W-1:0] VEC_FIRST = 16'hFFFA;
  localparam int I_BIT = 2;
  localparam int B_BIT = 4;
  localparam int U_BIT = 5;

  typedef enum logic [3:0] {
    S_RLO, S_RHI, S_IDLE, S_PUSH_H, S_PUSH_L, S_PUSH_P,
    S_VLO, S_VHI, S_PULL_P, S_PULL_L, S_PULL_H
  } seqState_e;

  typedef enum logic [1:0] { A_STK, A_STKUP, A_VLO, A_VHI } addrSel_e;
  typedef enum logic [1:0] { W_PCH, W_PCL, W_STAT, W_NONE } wdSel_e;
  typedef enum logic [1:0] { SP_HOLD, SP_DEC, SP_INC, SP_RSV } spStep_e;
  // vector index: address = VEC_FIRST + 2*index
  typedef enum logic [1:0] { V_NMI = 2'd0, V_RST = 2'd1, V_IRQ = 2'd2, V_RSV = 2'd3 } vecSel_e;

  typedef struct packed {
    logic     capture;
    addrSel_e addrSel;
    vecSel_e  vecSel;
    wdSel_e   wdSel;
    spStep_e  spStep;
    logic     we;
    logic     re;
    logic     latchLo;
    logic     pcFromMem;
    logic     statusSetI;
    logic     statusFromMem;
    logic     spLoad;
    logic     bFlag;
  } seqStrobe_t;

endpackage

// File: rtl/int_entry_ctrl.sv
module int_entry_ctrl
  import int_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       irqN,
  input  logic       nmiN,
  input  logic       instrEnd,
  input  logic       penult,
  input  logic       brkReq,
  input  logic       rtiReq,
  input  logic       iFlag,
  output seqStrobe_t stb,
  output logic       busy
);

  seqState_e state, nextState;
  logic nmiPrev, nmiPend, condLast, armed, isBrk;
  vecSel_e vecReg;

  logic nmiFall, irqLive, reqLive;
  logic startHw, startBrk, startRti, startAny;

  assign nmiFall  = nmiPrev & ~nmiN;
  assign irqLive  = ~irqN & ~iFlag;
  assign reqLive  = nmiPend | nmiFall | irqLive;
  assign startHw  = (state == S_IDLE) & instrEnd & armed;
  assign startBrk = (state == S_IDLE) & instrEnd & ~armed & brkReq;
  assign startRti = (state == S_IDLE) & instrEnd & ~armed & ~brkReq & rtiReq;
  assign startAny = startHw | startBrk | startRti;
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_RLO;
      nmiPrev  <= 1'b1;
      nmiPend  <= 1'b0;
      condLast <= 1'b0;
      armed    <= 1'b0;
      isBrk    <= 1'b0;
      vecReg   <= V_IRQ;
    end else begin
      state    <= nextState;
      nmiPrev  <= nmiN;
      condLast <= reqLive;
      if (nmiFall)
        nmiPend <= 1'b1;
      else if (startHw && nmiPend)
        nmiPend <= 1'b0;
      if (startAny)
        armed <= 1'b0;
      else if (penult)
        armed <= condLast;
      if (startAny) begin
        isBrk  <= startBrk;
        vecReg <= (startHw && nmiPend) ? V_NMI : V_IRQ;
      end
    end
  end

  always_comb begin
    nextState = state;
    stb = '0;
    stb.wdSel = W_NONE;
    stb.vecSel = vecReg;
    unique case (state)
      S_RLO: begin
        stb.addrSel = A_VLO; stb.vecSel = V_RST;
        stb.re = 1'b1; stb.latchLo = 1'b1; stb.capture = 1'b1;
        nextState = S_RHI;
      end
      S_RHI: begin
        stb.addrSel = A_VHI; stb.vecSel = V_RST;
        stb.re = 1'b1; stb.pcFromMem = 1'b1; stb.statusSetI = 1'b1;
        nextState = S_IDLE;
      end
      S_IDLE: begin
        if (startAny) stb.capture = 1'b1;
        if (startHw || startBrk) nextState = S_PUSH_H;
        else if (startRti)       nextState = S_PULL_P;
      end
      S_PUSH_H: begin
        stb.addrSel = A_STK; stb.we = 1'b1; stb.wdSel = W_PCH; stb.spStep = SP_DEC;
        nextState = S_PUSH_L;
      end
      S_PUSH_L: begin
        stb.addrSel = A_STK; stb.we = 1'b1; stb.wdSel = W_PCL; stb.spStep = SP_DEC;
        nextState = S_PUSH_P;
      end
      S_PUSH_P: begin
        stb.addrSel = A_STK; stb.we = 1'b1; stb.wdSel = W_STAT; stb.spStep = SP_DEC;
        stb.bFlag = isBrk;
        nextState = S_VLO;
      end
      S_VLO: begin
        stb.addrSel = A_VLO; stb.re = 1'b1; stb.latchLo = 1'b1;
        nextState = S_VHI;
      end
      S_VHI: begin
        stb.addrSel = A_VHI; stb.re = 1'b1; stb.pcFromMem = 1'b1;
        stb.statusSetI = 1'b1; stb.spLoad = 1'b1;
        nextState = S_IDLE;
      end
      S_PULL_P: begin
        stb.addrSel = A_STKUP; stb.re = 1'b1; stb.statusFromMem = 1'b1; stb.spStep = SP_INC;
        nextState = S_PULL_L;
      end
      S_PULL_L: begin
        stb.addrSel = A_STKUP; stb.re = 1'b1; stb.latchLo = 1'b1; stb.spStep = SP_INC;
        nextState = S_PULL_H;
      end
      S_PULL_H: begin
        stb.addrSel = A_STKUP; stb.re = 1'b1; stb.pcFromMem = 1'b1; stb.spStep = SP_INC;
        stb.spLoad = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/int_entry_dpath.sv
module int_entry_dpath
  import int_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [7:0]        spIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  output logic [ADDR_W-1:0] pcOut,
  output logic              pcLoad,
  output logic [DATA_W-1:0] statusOut,
  output logic              statusLoad,
  output logic [7:0]        spOut,
  output logic              spLoad
);

  logic [7:0]        spWork;
  logic [ADDR_W-1:0] pcHold;
  logic [DATA_W-1:0] statHold;
  logic [DATA_W-1:0] loByte;
  logic [7:0]        spUp;
  logic [ADDR_W-1:0] vecBase;
  logic [DATA_W-1:0] pushStat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spWork   <= '0;
      pcHold   <= '0;
      statHold <= '0;
      loByte   <= '0;
    end else begin
      if (stb.capture) begin
        spWork   <= spIn;
        pcHold   <= pcIn;
        statHold <= statusIn;
      end else if (stb.spStep == SP_DEC) begin
        spWork <= spWork - 8'd1;
      end else if (stb.spStep == SP_INC) begin
        spWork <= spUp;
      end
      if (stb.latchLo) loByte <= memRdata;
    end
  end

  assign spUp    = spWork + 8'd1;
  assign vecBase = VEC_FIRST + {{(ADDR_W-3){1'b0}}, stb.vecSel, 1'b0};

  always_comb begin
    pushStat = statHold;
    pushStat[U_BIT] = 1'b1;
    pushStat[B_BIT] = stb.bFlag;
  end

  always_comb begin
    unique case (stb.addrSel)
      A_STK:   memAddr = {STACK_PAGE, spWork};
      A_STKUP: memAddr = {STACK_PAGE, spUp};
      A_VLO:   memAddr = vecBase;
      default: memAddr = vecBase | {{(ADDR_W-1){1'b0}}, 1'b1};
    endcase
    unique case (stb.wdSel)
      W_PCH:   memWdata = pcHold[ADDR_W-1:DATA_W];
      W_PCL:   memWdata = pcHold[DATA_W-1:0];
      W_STAT:  memWdata = pushStat;
      default: memWdata = '0;
    endcase
  end

  assign memWe      = stb.we;
  assign memRe      = stb.re;
  assign pcOut      = {memRdata, loByte};
  assign pcLoad     = stb.pcFromMem;
  assign statusOut  = stb.statusFromMem ? memRdata : (statHold | (8'h01 << I_BIT));
  assign statusLoad = stb.statusFromMem | stb.statusSetI;
  assign spOut      = (stb.spStep == SP_INC) ? spUp : spWork;
  assign spLoad     = stb.spLoad;

endmodule

// File: rtl/cpu_int_entry.sv
module cpu_int_entry
  import int_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqN,
  input  logic              nmiN,
  input  logic              instrEnd,
  input  logic              penult,
  input  logic              brkReq,
  input  logic              rtiReq,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [7:0]        spIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  output logic [ADDR_W-1:0] pcOut,
  output logic              pcLoad,
  output logic [DATA_W-1:0] statusOut,
  output logic              statusLoad,
  output logic [7:0]        spOut,
  output logic              spLoad,
  output logic              busy
);

  seqStrobe_t stb;

  int_entry_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .irqN(irqN), .nmiN(nmiN),
    .instrEnd(instrEnd), .penult(penult), .brkReq(brkReq), .rtiReq(rtiReq),
    .iFlag(statusIn[I_BIT]), .stb(stb), .busy(busy)
  );

  int_entry_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .pcIn(pcIn), .statusIn(statusIn),
    .spIn(spIn), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRe(memRe), .pcOut(pcOut), .pcLoad(pcLoad),
    .statusOut(statusOut), .statusLoad(statusLoad), .spOut(spOut), .spLoad(spLoad)
  );

endmodule

// File: rtl/cpu_int_entry_chk.sv
module cpu_int_entry_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        memWe,
  input logic        memRe,
  input logic [15:0] memAddr,
  input logic        pcLoad,
  input logic [7:0]  statusOut
);

  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memWe && !memRe));

  p_stack_page_r2: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr[15:8] == 8'h01));

  p_push_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> (memAddr == $past(memAddr) - 16'd1));

  p_read_target_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRe |-> (memAddr[15:8] == 8'h01 || memAddr[15:3] == 13'h1FFF));

  p_vec_sets_i_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && memAddr[15:8] != 8'h01) |-> statusOut[2]);

endmodule

bind cpu_int_entry cpu_int_entry_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .memWe(memWe), .memRe(memRe),
  .memAddr(memAddr), .pcLoad(pcLoad), .statusOut(statusOut)
);

// File: tb/sim_cpu_int_entry.sv
module sim_cpu_int_entry;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqN = 1'b1, nmiN = 1'b1;
  logic instrEnd = 1'b0, penult = 1'b0, brkReq = 1'b0, rtiReq = 1'b0;
  logic [15:0] pcReg = 16'h1234;
  logic [7:0]  pReg = 8'h20;
  logic [7:0]  spReg = 8'hFF;
  logic [7:0]  memRdata;
  logic [15:0] memAddr, pcOut;
  logic [7:0]  memWdata, statusOut, spOut;
  logic memWe, memRe, pcLoad, statusLoad, spLoad, busy;

  int nTests = 0, nFail = 0, busyCycles = 0;
  bit finished = 0;
  logic [7:0] stk [256];

  typedef struct { int kind; logic [15:0] val; string tag; } sbItem_t;
  sbItem_t sbQ[$];

  always #2 clk = ~clk;

  cpu_int_entry u0 (
    .clk(clk), .rstN(rstN), .irqN(irqN), .nmiN(nmiN), .instrEnd(instrEnd),
    .penult(penult), .brkReq(brkReq), .rtiReq(rtiReq), .pcIn(pcReg),
    .statusIn(pReg), .spIn(spReg), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memWe(memWe), .memRe(memRe), .pcOut(pcOut),
    .pcLoad(pcLoad), .statusOut(statusOut), .statusLoad(statusLoad),
    .spOut(spOut), .spLoad(spLoad), .busy(busy)
  );

  function automatic logic [7:0] romByte(input logic [15:0] a);
    case (a)
      16'hFFFA: romByte = 8'h23;  16'hFFFB: romByte = 8'hA1;
      16'hFFFC: romByte = 8'h00;  16'hFFFD: romByte = 8'h80;
      16'hFFFE: romByte = 8'h56;  16'hFFFF: romByte = 8'hB4;
      default:  romByte = 8'hEA;
    endcase
  endfunction

  assign memRdata = (memAddr[15:8] == 8'h01) ? stk[memAddr[7:0]] : romByte(memAddr);

  // core model: registers follow the load strobes, stack RAM takes writes
  always @(posedge clk) begin
    if (memWe) stk[memAddr[7:0]] <= memWdata;
    if (pcLoad) pcReg <= pcOut;
    if (statusLoad) pReg <= statusOut;
    if (spLoad) spReg <= spOut;
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // kinds: 0 write (val = {addr lsb... } split in two items), 1 pc, 2 status, 3 sp, 4 write addr, 5 write data
  task automatic expWrite(input logic [15:0] a, input logic [7:0] d, input string tag);
    sbQ.push_back('{4, a, tag});
    sbQ.push_back('{5, {8'h00, d}, tag});
  endtask
  task automatic expLoad(input int k, input logic [15:0] v, input string tag);
    sbQ.push_back('{k, v, tag});
  endtask

  task automatic popCmp(input int k, input logic [15:0] act);
    sbItem_t it;
    if (sbQ.size() == 0) begin
      check(0, "unexpected bus event", act, 16'hxxxx);
      return;
    end
    it = sbQ.pop_front();
    check(it.kind == k && it.val == act, it.tag, act, it.val);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) busyCycles++;
      if (memWe) begin popCmp(4, memAddr); popCmp(5, {8'h00, memWdata}); end
      if (pcLoad) popCmp(1, pcOut);
      if (statusLoad) popCmp(2, {8'h00, statusOut});
      if (spLoad) popCmp(3, {8'h00, spOut});
    end
  end

  task automatic runInstr(input bit brk, input bit rti, input bit lateIrq);
    @(negedge clk); penult = 0; instrEnd = 0;
    @(negedge clk); penult = 1; if (lateIrq) irqN = 0;
    @(negedge clk); penult = 0; instrEnd = 1; brkReq = brk; rtiReq = rti;
    @(negedge clk); instrEnd = 0; brkReq = 0; rtiReq = 0;
    while (busy) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    check(sbQ.size() == 0, tag, 16'(sbQ.size()), 16'd0);
  endtask

  task automatic expEntry(input logic [15:0] pc, input logic [7:0] pushed, input logic [15:0] vec,
                          input logic [7:0] st, input string tag);
    expWrite(16'h01FF, pc[15:8], {tag, " R2 pch"});
    expWrite(16'h01FE, pc[7:0], {tag, " R2 pcl"});
    expWrite(16'h01FD, pushed, {tag, " R3 status"});
    expLoad(1, vec, {tag, " R4 vector"});
    expLoad(2, {8'h00, st | 8'h04}, {tag, " R5 I set"});
    expLoad(3, 16'h00FC, {tag, " R2 sp"});
  endtask

  task automatic expReturn(input logic [7:0] st, input logic [15:0] pc, input string tag);
    expLoad(2, {8'h00, st}, {tag, " R10 status"});
    expLoad(1, pc, {tag, " R10 pc"});
    expLoad(3, 16'h00FF, {tag, " R10 sp"});
  endtask

  initial begin
    int b0;
    // R1: reset fetch
    expLoad(1, 16'h8000, "R1 reset pc");
    expLoad(2, 16'h0024, "R1 reset I");
    repeat (3) @(negedge clk);
    check(busyCycles == 0, "R1 quiet in reset", 16'(busyCycles), 0);
    rstN = 1;
    repeat (6) @(negedge clk);
    drained("R1 reset sequence");
    check(pcReg == 16'h8000, "R1 pc after reset", pcReg, 16'h8000);

    // R6: IRQ masked while I set
    irqN = 0; b0 = busyCycles;
    runInstr(0, 0, 0); runInstr(0, 0, 0);
    check(busyCycles == b0, "R6 masked irq", 16'(busyCycles - b0), 0);
    check(pcReg == 16'h8000, "R6 pc unchanged", pcReg, 16'h8000);
    irqN = 1;

    // R6/R3 hardware IRQ entry then R10 return
    @(negedge clk); pReg = 8'hC3; pcReg = 16'h4000;
    irqN = 0;
    expEntry(16'h4000, 8'hE3, 16'hB456, 8'hC3, "R6 irq");
    runInstr(0, 0, 0);
    drained("R6 irq entry");
    irqN = 1;
    expReturn(8'hE3, 16'h4000, "irq");
    runInstr(0, 1, 0);
    drained("R10 return");

    // R3 break: B set, shared vector
    @(negedge clk); pcReg = 16'h5002;
    expEntry(16'h5002, 8'hF3, 16'hB456, 8'hE3, "R3 brk");
    runInstr(1, 0, 0);
    drained("R3 brk entry");
    expReturn(8'hF3, 16'h5002, "brk");
    runInstr(0, 1, 0);
    drained("R10 brk return");

    // R7 NMI ignores I, one entry per edge
    @(negedge clk); pReg = 8'h24; pcReg = 16'h6000; nmiN = 0;
    expEntry(16'h6000, 8'h24, 16'hA123, 8'h24, "R7 nmi");
    runInstr(0, 0, 0);
    drained("R7 nmi entry");
    expReturn(8'h24, 16'h6000, "nmi");
    runInstr(0, 1, 0);
    b0 = busyCycles;
    runInstr(0, 0, 0); runInstr(0, 0, 0);
    check(busyCycles == b0, "R7 held low no retrigger", 16'(busyCycles - b0), 0);
    nmiN = 1;

    // R9 late request waits one instruction
    @(negedge clk); pReg = 8'h20; pcReg = 16'h7000;
    b0 = busyCycles;
    runInstr(0, 0, 1);
    check(busyCycles == b0, "R9 late irq deferred", 16'(busyCycles - b0), 0);
    expEntry(16'h7000, 8'h20, 16'hB456, 8'h20, "R9 irq");
    runInstr(0, 0, 0);
    drained("R9 irq after next instr");
    irqN = 1;
    expReturn(8'h20, 16'h7000, "r9");
    runInstr(0, 1, 0);
    drained("R10 r9 return");

    // R8 NMI beats IRQ
    @(negedge clk); pcReg = 16'h7100; irqN = 0; nmiN = 0;
    expEntry(16'h7100, 8'h20, 16'hA123, 8'h20, "R8 both");
    runInstr(0, 0, 0);
    drained("R8 nmi priority");
    irqN = 1; nmiN = 1;
    repeat (4) @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      nTests++; nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule